// File: doc/BRIEF.md
# Transmit In-Band Command Decoder

This block sits between a transmit byte queue and a character serializer. With its command feature switched on, it watches the outgoing byte stream for a zero byte, which it treats as an escape marker and does not forward. The byte after the marker chooses an action. It can forward a literal zero, raise the line-break level, release the break, or pause the stream for a number of prescaler ticks given by a third byte. With the feature switched off, every byte is forwarded unchanged.

Both sides of the block use a valid/ready handshake. Data bytes pass through combinationally and are not buffered, so a forwarded byte is taken from upstream in the same cycle that the serializer accepts it. The serializer supplies a pulse at the end of each character time, and a prescaler supplies a periodic tick. The block drives a break-level control and a busy flag, which is raised while a command sequence is still being collected or carried out.

Top module: `txesc_top`

## Requirements
- R1: After reset, `busy`, `breakOn` and `outValid` are all low.
- R2: While the parser is idle with `cmdEnable` low, every byte including 0x00 is forwarded: `outValid` follows `inValid`, `outData` equals `inData`, and `inReady` follows `outReady`.
- R3: With `cmdEnable` high, a non-zero byte is forwarded as in R2. A 0x00 byte is consumed at once (`inReady` high) without raising `outValid`.
- R4: The pair 0x00, 0x00 forwards exactly one 0x00 data byte, offered on the second byte's handshake.
- R5: The pair 0x00, 0x81 raises `breakOn` in the cycle after the 0x81 is accepted. `inReady` then stays low until the first `charDone` pulse that arrives after that point, which makes the break last at least one character time.
- R6: While `breakOn` is high, data bytes (forwarded or literal zero) are accepted and dropped, and `outValid` stays low.
- R7: The pair 0x00, 0x83 clears `breakOn` in the cycle after the 0x83 is accepted. Data is forwarded again from then on.
- R8: The sequence 0x00, 0x82, N with N non-zero holds `inReady` low until N `tick` pulses have been counted. Counting starts in the cycle after N is accepted, and the stall ends in the cycle after the N-th tick.
- R9: The sequence 0x00, 0x82, 0x00 causes no pause. The parser is idle in the cycle after the count byte.
- R10: A delay sequence that directly follows a break sequence keeps `breakOn` high for the whole delay.
- R11: An escape followed by any second byte other than 0x00, 0x81, 0x82 or 0x83 consumes both bytes, forwards nothing and leaves the parser idle.
- R12: `busy` is high exactly while the parser is between an escape and the end of its command: waiting for a command byte, waiting for a count byte, counting a delay, or waiting out the minimum break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdEnable | input | 1 | Turns on in-band command decoding |
| inValid | input | 1 | Upstream byte valid |
| inData | input | 8 | Upstream byte |
| inReady | output | 1 | Upstream byte accepted when high with `inValid` |
| outValid | output | 1 | Data byte offered to the serializer |
| outData | output | 8 | Data byte to the serializer |
| outReady | input | 1 | Serializer accepts the offered byte |
| tick | input | 1 | Single-cycle prescaler tick |
| charDone | input | 1 | Single-cycle end-of-character-time pulse |
| breakOn | output | 1 | Line-break level request |
| busy | output | 1 | A command sequence is in progress |

## Verification
The bench builds the block with its default 8-bit data path and an 8-bit delay counter. This allows the largest count byte, 0xFF, to be run to completion at a tick every third cycle, alongside counts of zero and three. With the counter width equal to the byte width, the zero-count bypass and the full range of the count register are both reached. The ready and valid gap patterns are varied so that pass-through stalls can be seen both while a break is active and while it is not.

// File: rtl/txesc_pkg.sv
package txesc_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ESC,
    PS_ARG,
    PS_DELAY,
    PS_BRKMIN
  } parseSt_t;

  typedef struct packed {
    logic setBreak;
    logic clrBreak;
    logic loadCount;
    logic decCount;
  } dpStrobe_t;

endpackage

// File: rtl/txesc_dp.sv
module txesc_dp
  import txesc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              breakOn,
  output logic              countLast,
  output logic              argZero
);

  localparam int ARG_BITS = (CNT_W < DATA_W) ? CNT_W : DATA_W;

  logic [CNT_W-1:0] argValue;
  logic [CNT_W-1:0] dlyCount;

  generate
    if (CNT_W > DATA_W) begin : gWideCnt
      assign argValue = {{(CNT_W-DATA_W){1'b0}}, inData};
    end else begin : gNarrowCnt
      assign argValue = inData[ARG_BITS-1:0];
    end
  endgenerate

  assign outData   = inData;
  assign argZero   = (argValue == '0);
  assign countLast = (dlyCount == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyCount <= '0;
    end else if (strobe.loadCount) begin
      dlyCount <= argValue;
    end else if (strobe.decCount && dlyCount != '0) begin
      dlyCount <= dlyCount - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      breakOn <= 1'b0;
    end else if (strobe.setBreak) begin
      breakOn <= 1'b1;
    end else if (strobe.clrBreak) begin
      breakOn <= 1'b0;
    end
  end

  AST_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadCount && !strobe.decCount) |=> $stable(dlyCount)); // R8
  AST_BREAK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setBreak |=> breakOn); // R5
  AST_BREAK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrBreak |=> !breakOn); // R7

endmodule

// File: rtl/txesc_ctrl.sv
module txesc_ctrl
  import txesc_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  ESC_CODE   = 8'h00,
  parameter logic [7:0]  OP_BREAK   = 8'h81,
  parameter logic [7:0]  OP_DELAY   = 8'h82,
  parameter logic [7:0]  OP_UNBREAK = 8'h83
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEnable,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  input  logic              tick,
  input  logic              charDone,
  input  logic              breakOn,
  input  logic              countLast,
  input  logic              argZero,
  output logic              inReady,
  output logic              outValid,
  output logic              busy,
  output dpStrobe_t         strobe
);

  parseSt_t state, nextSt;
  logic     escHit;

  assign escHit = (inData == DATA_W'(ESC_CODE));
  assign busy   = (state != PS_IDLE);

  always_comb begin
    nextSt   = state;
    inReady  = 1'b0;
    outValid = 1'b0;
    strobe   = '0;
    unique case (state)
      PS_IDLE: begin
        if (cmdEnable && escHit) begin
          inReady = 1'b1;
          if (inValid) nextSt = PS_ESC;
        end else begin
          outValid = inValid && !breakOn;
          inReady  = breakOn || outReady;
        end
      end
      PS_ESC: begin
        if (escHit) begin
          outValid = inValid && !breakOn;
          inReady  = breakOn || outReady;
          if (inValid && inReady) nextSt = PS_IDLE;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            if (inData == DATA_W'(OP_BREAK)) begin
              strobe.setBreak = 1'b1;
              nextSt          = PS_BRKMIN;
            end else if (inData == DATA_W'(OP_DELAY)) begin
              nextSt = PS_ARG;
            end else if (inData == DATA_W'(OP_UNBREAK)) begin
              strobe.clrBreak = 1'b1;
              nextSt          = PS_IDLE;
            end else begin
              nextSt = PS_IDLE;
            end
          end
        end
      end
      PS_ARG: begin
        inReady = 1'b1;
        if (inValid) begin
          if (argZero) begin
            nextSt = PS_IDLE;
          end else begin
            strobe.loadCount = 1'b1;
            nextSt           = PS_DELAY;
          end
        end
      end
      PS_DELAY: begin
        if (tick) begin
          strobe.decCount = 1'b1;
          if (countLast) nextSt = PS_IDLE;
        end
      end
      PS_BRKMIN: begin
        if (charDone) nextSt = PS_IDLE;
      end
      default: nextSt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PS_IDLE;
    else       state <= nextSt;
  end

  AST_DELAY_WAITS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_DELAY && !tick) |=> (state == PS_DELAY)); // R8
  AST_BRKMIN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_BRKMIN && !charDone) |=> (state == PS_BRKMIN)); // R5
  AST_BREAK_ENTRY_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setBreak |=> (busy && !inReady)); // R5

endmodule

// File: rtl/txesc_top.sv
module txesc_top
  import txesc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEnable,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady,
  input  logic              tick,
  input  logic              charDone,
  output logic              breakOn,
  output logic              busy
);

  dpStrobe_t strobe;
  logic      countLast;
  logic      argZero;

  txesc_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable),
    .inValid(inValid), .inData(inData), .outReady(outReady),
    .tick(tick), .charDone(charDone), .breakOn(breakOn),
    .countLast(countLast), .argZero(argZero),
    .inReady(inReady), .outValid(outValid), .busy(busy), .strobe(strobe)
  );

  txesc_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .outData(outData), .breakOn(breakOn),
    .countLast(countLast), .argZero(argZero)
  );

  AST_NO_DATA_IN_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    breakOn |-> !outValid); // R6
  AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdEnable && inValid && !breakOn) |-> (outValid && outData == inData)); // R2

endmodule

// File: tb/sim_txesc_top.sv
module sim_txesc_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdEnable = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'hEE;
  logic       inReady, outValid, breakOn, busy;
  logic [7:0] outData;
  logic       outReady = 1'b1;
  logic       tick = 1'b0;
  logic       charDone = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit running = 0;
  bit done = 0;
  int rdyMode = 0;
  int gapMode = 0;
  string curReq = "R2";
  logic [7:0] q[$];

  int mst = 0;
  int mcnt = 0;
  bit mbrk = 0;

  always #2 clk = ~clk;

  txesc_top u0 (
    .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .tick(tick), .charDone(charDone), .breakOn(breakOn), .busy(busy)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      bit eRdy, eOv, eBusy, fire, escB;
      cyc++;
      tick     = (cyc % 3 == 0);
      charDone = (cyc % 5 == 0);
      outReady = (rdyMode != 0) ? cyc[0] : 1'b1;
      inValid  = (q.size() > 0) && !(gapMode != 0 && cyc % 4 == 1);
      inData   = (q.size() > 0) ? q[0] : 8'hEE;
      #1;
      escB  = (inData == 8'h00);
      eRdy  = 0;
      eOv   = 0;
      eBusy = (mst != 0);
      case (mst)
        0: if (cmdEnable && escB) eRdy = 1;
           else begin eOv = inValid && !mbrk; eRdy = mbrk || outReady; end
        1: if (escB) begin eOv = inValid && !mbrk; eRdy = mbrk || outReady; end
           else eRdy = 1;
        2: eRdy = 1;
        default: eRdy = 0;
      endcase
      chk(curReq, "inReady", 32'(inReady), 32'(eRdy));
      chk(curReq, "outValid", 32'(outValid), 32'(eOv));
      if (eOv) chk(curReq, "outData", 32'(outData), 32'(inData));
      chk(curReq, "breakOn", 32'(breakOn), 32'(mbrk));
      chk("R12", "busy", 32'(busy), 32'(eBusy));
      fire = inValid && eRdy;
      case (mst)
        0: if (fire && cmdEnable && escB) mst = 1;
        1: if (fire) begin
             if (escB) mst = 0;
             else if (inData == 8'h81) begin mbrk = 1; mst = 4; end
             else if (inData == 8'h82) mst = 2;
             else if (inData == 8'h83) begin mbrk = 0; mst = 0; end
             else mst = 0;
           end
        2: if (fire) begin
             if (inData == 8'h00) mst = 0;
             else begin mcnt = int'(inData); mst = 3; end
           end
        3: if (tick) begin mcnt--; if (mcnt == 0) mst = 0; end
        default: if (charDone) mst = 0;
      endcase
      if (fire) void'(q.pop_front());
    end
  end

  task automatic drain();
    while (q.size() != 0 || mst != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "breakOn in reset", 32'(breakOn), 32'd0);
    chk("R1", "outValid in reset", 32'(outValid), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "busy after reset", 32'(busy), 32'd0);
    chk("R1", "breakOn after reset", 32'(breakOn), 32'd0);
    running = 1;

    // R2: feature off, zero passes as data
    curReq = "R2"; cmdEnable = 0; rdyMode = 1;
    q.push_back(8'h00); q.push_back(8'h41); q.push_back(8'h00); q.push_back(8'h7F);
    drain();

    // R3: feature on, plain bytes with valid gaps
    curReq = "R3"; cmdEnable = 1; gapMode = 1;
    q.push_back(8'h41); q.push_back(8'h42); q.push_back(8'h43);
    drain();

    // R4: literal zero
    curReq = "R4";
    q.push_back(8'h00); q.push_back(8'h00); q.push_back(8'h55);
    drain();

    // R11: unknown command byte
    curReq = "R11"; gapMode = 0;
    q.push_back(8'h00); q.push_back(8'h47); q.push_back(8'h33);
    q.push_back(8'h00); q.push_back(8'hFF); q.push_back(8'h34);
    drain();

    // R5, R6, R10, R7: break, dropped data, delay in break, release
    curReq = "R5";
    q.push_back(8'h00); q.push_back(8'h81);
    drain();
    #1;
    chk("R5", "break held", 32'(breakOn), 32'd1);
    curReq = "R6";
    q.push_back(8'h61); q.push_back(8'h00); q.push_back(8'h00); q.push_back(8'h62);
    drain();
    curReq = "R10";
    q.push_back(8'h00); q.push_back(8'h81); q.push_back(8'h00); q.push_back(8'h82); q.push_back(8'h04);
    drain();
    #1;
    chk("R10", "break after delay", 32'(breakOn), 32'd1);
    curReq = "R7"; rdyMode = 0;
    q.push_back(8'h00); q.push_back(8'h83); q.push_back(8'h70); q.push_back(8'h71);
    drain();
    #1;
    chk("R7", "break released", 32'(breakOn), 32'd0);

    // R8: delays, including the largest count
    curReq = "R8"; rdyMode = 1;
    q.push_back(8'h00); q.push_back(8'h82); q.push_back(8'h03); q.push_back(8'h44);
    drain();
    q.push_back(8'h00); q.push_back(8'h82); q.push_back(8'hFF); q.push_back(8'h46);
    drain();

    // R9: zero delay
    curReq = "R9";
    q.push_back(8'h00); q.push_back(8'h82); q.push_back(8'h00); q.push_back(8'h45);
    drain();

    running = 0;
    @(negedge clk);
    finishRun();
  end

endmodule